// File: doc/BRIEF.md
# Constant-Shift Reconfigurable Coefficient Multiplier

This block multiplies a signed sample by an unsigned fractional coefficient that can change on every cycle. It uses no hardware multiplier. A small shared pattern bank uses three adders to form every multiple of the sample from 0x to 7x. The coefficient word is cut into 3-bit slices, starting at its most significant end. Each slice selects one bank entry through its own multiplexer. That entry then gets a fixed shift set by the slice position. A balanced adder tree sums the shifted terms into a result at full precision.

The block is meant to be the coefficient multiplier of a filter tap whose coefficient comes from outside, for example from a table indexed per cycle. The coefficient `coef_i` is read as h = coef_i / 2^N. Bit `coef_i[N-1]` is the first fraction bit, with weight 1/2. The output `prod_o` holds x·h with N fraction bits, so as an integer it equals x·coef_i exactly. When `OUT_REG` is set (the default), the result is registered, with one cycle of latency and a synchronous active-high reset.

Top module: `csm_coef_mult`

## Requirements
- R1: With OUT_REG=1, `prod_o` read as a two's-complement integer equals signed(x_i)·unsigned(coef_i) from the previous rising edge. This holds for every input pair, including back-to-back changes on consecutive cycles.
- R2: While `rst` is high at a rising edge, `prod_o` becomes 0 at that edge, whatever the inputs are.
- R3: A zero coefficient, or a zero sample, gives a product of 0.
- R4: Slice k (counting from 0 at the MSB end) covers coef_i bits [N-1-3k : N-3-3k]. Its 3-bit value p contributes p·x·2^(N-3-3k). So a coefficient with a single nonzero slice gives exactly that term.
- R5: Every 3-bit slice value from 0 to 7 selects the multiple 0x to 7x of the sample, with negative samples included.
- R6: When N is not a multiple of 3, the lowest (N mod 3) coefficient bits form a narrower trailing slice with weight 1. With N=16, coef_i=1 gives prod_o = x.
- R7: An all-ones coefficient gives x·(2^N − 1) exactly, both at the most negative and at the most positive sample.
- R8: For a nonzero coefficient, the product has the sign of the sample: the MSB is set when x<0, and the value is greater than 0 when x>0. The most negative sample does not overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| x_i | input | W | Signed two's-complement sample |
| coef_i | input | N | Unsigned fractional coefficient; bit N-1 has weight 1/2 |
| prod_o | output | W+N+2 | Signed product x·coef_i, holding N fraction bits |

## Verification
On every cycle, the bound checker compares the registered product with a plain signed multiply of the previous inputs. It also checks the reset clearing, the zero-operand results and the sign of the product. The bench's directed scenarios show the behaviours that depend on coefficient structure: each slice position in isolation, all eight patterns in one slice, the narrow trailing slice, and the all-ones worst case at both extremes of the sample. A seeded random stream, with a new input pair on every cycle, exposes latency or slice-ordering faults that single vectors could hide.

// File: rtl/csm_pkg.sv
package csm_pkg;

  // Every full coefficient slice spans this many bits.
  localparam int SLICE_W = 3;
  // Number of pattern multiples formed by the shared bank (0x .. 7x).
  localparam int BANK_SZ = 1 << SLICE_W;

  // Number of slices needed for an n-bit coefficient.
  function automatic int slice_count(input int n);
    return (n + SLICE_W - 1) / SLICE_W;
  endfunction

  // Width of slice k; only the last slice can be narrower.
  function automatic int slice_width(input int n, input int k);
    int rem;
    rem = n - k * SLICE_W;
    return (rem >= SLICE_W) ? SLICE_W : rem;
  endfunction

  // Bit position of the least significant bit of slice k inside the
  // coefficient word; it is also the left shift applied to that slice's
  // term when the product is aligned to integer units.
  function automatic int slice_lsb(input int n, input int k);
    return n - k * SLICE_W - slice_width(n, k);
  endfunction

endpackage

// File: rtl/csm_pattern_bank.sv
// Forms every multiple 0x..7x of the sample once, with three adders.
module csm_pattern_bank
  import csm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]               x_i,
  output logic [BANK_SZ*(W+3)-1:0]   bank_o
);

  localparam int BW = W + 3;

  logic signed [BW-1:0] m0, m1, m2, m3, m4, m5, m6, m7;

  // Single-one patterns are wiring only.
  assign m0 = '0;
  assign m1 = BW'(signed'(x_i));
  assign m2 = m1 <<< 1;
  assign m4 = m1 <<< 2;

  // Adder 1: pattern 110 = 4x + 2x.
  assign m6 = m4 + m2;
  // Pattern 011 is pattern 110 moved down one place: no adder.
  assign m3 = m6 >>> 1;
  // Adder 2: pattern 111 reuses 110.
  assign m7 = m6 + m1;
  // Adder 3: pattern 101.
  assign m5 = m4 + m1;

  assign bank_o = {m7, m6, m5, m4, m3, m2, m1, m0};

endmodule

// File: rtl/csm_slice_term.sv
// One coefficient slice: picks a bank entry and applies its fixed shift.
module csm_slice_term #(
  parameter int BW  = 19,
  parameter int PW  = 34,
  parameter int SB  = 3,
  parameter int LSB = 0
) (
  input  logic [SB-1:0]           sel_i,
  input  logic [(1<<SB)*BW-1:0]   bank_i,
  output logic signed [PW-1:0]    term_o
);

  localparam int NIN = 1 << SB;

  logic signed [BW-1:0] pick;

  generate
    if (NIN == 8) begin : g_full
      // 8:1 selection over the whole bank.
      always_comb begin
        case (sel_i)
          3'd0:    pick = signed'(bank_i[0*BW +: BW]);
          3'd1:    pick = signed'(bank_i[1*BW +: BW]);
          3'd2:    pick = signed'(bank_i[2*BW +: BW]);
          3'd3:    pick = signed'(bank_i[3*BW +: BW]);
          3'd4:    pick = signed'(bank_i[4*BW +: BW]);
          3'd5:    pick = signed'(bank_i[5*BW +: BW]);
          3'd6:    pick = signed'(bank_i[6*BW +: BW]);
          default: pick = signed'(bank_i[7*BW +: BW]);
        endcase
      end
    end else begin : g_narrow
      // Trailing slice: a 4:1 or 2:1 selection over the low entries.
      always_comb begin
        pick = signed'(bank_i[sel_i*BW +: BW]);
      end
    end
  endgenerate

  generate
    if (LSB == 0) begin : g_noshift
      assign term_o = PW'(pick);
    end else begin : g_shift
      assign term_o = PW'(pick) <<< LSB;
    end
  endgenerate

endmodule

// File: rtl/csm_adder_tree.sv
// Balanced binary adder tree laid out as a heap: node 1 is the root,
// leaves sit at LEAVES..2*LEAVES-1, unused leaves are tied to zero.
module csm_adder_tree #(
  parameter int PW = 34,
  parameter int NT = 6
) (
  input  logic [NT*PW-1:0]       terms_i,
  output logic signed [PW-1:0]   sum_o
);

  localparam int LV     = (NT > 1) ? $clog2(NT) : 0;
  localparam int LEAVES = 1 << LV;

  logic signed [PW-1:0] node [1:2*LEAVES-1];

  generate
    for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
      if (j < NT) begin : g_used
        assign node[LEAVES + j] = signed'(terms_i[j*PW +: PW]);
      end else begin : g_pad
        assign node[LEAVES + j] = '0;
      end
    end
    for (genvar i = 1; i < LEAVES; i++) begin : g_sum
      assign node[i] = node[2*i] + node[2*i + 1];
    end
  endgenerate

  assign sum_o = node[1];

endmodule

// File: rtl/csm_coef_mult.sv
// Constant-shift coefficient multiplier: shared pattern bank, one mux per
// 3-bit coefficient slice, hardwired shifts and an adder tree.
module csm_coef_mult
  import csm_pkg::*;
#(
  parameter int W       = 16,
  parameter int N       = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     x_i,
  input  logic [N-1:0]     coef_i,
  output logic [W+N+1:0]   prod_o
);

  localparam int BW = W + 3;
  localparam int PW = W + N + 2;
  localparam int NS = slice_count(N);

  logic [BANK_SZ*BW-1:0] bank;
  logic [NS*PW-1:0]      terms;
  logic signed [PW-1:0]  sum;

  csm_pattern_bank #(.W(W)) u_bank (
    .x_i    (x_i),
    .bank_o (bank)
  );

  generate
    for (genvar k = 0; k < NS; k++) begin : g_slice
      localparam int SB  = slice_width(N, k);
      localparam int LSB = slice_lsb(N, k);
      csm_slice_term #(
        .BW  (BW),
        .PW  (PW),
        .SB  (SB),
        .LSB (LSB)
      ) u_term (
        .sel_i  (coef_i[LSB +: SB]),
        .bank_i (bank[(1<<SB)*BW-1:0]),
        .term_o (terms[k*PW +: PW])
      );
    end
  endgenerate

  csm_adder_tree #(.PW(PW), .NT(NS)) u_tree (
    .terms_i (terms),
    .sum_o   (sum)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) prod_o <= '0;
        else     prod_o <= sum;
      end
    end else begin : g_comb
      assign prod_o = sum;
    end
  endgenerate

endmodule

// File: rtl/csm_coef_mult_chk.sv
module csm_coef_mult_chk #(
  parameter int W       = 16,
  parameter int N       = 16,
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [W-1:0]     x_i,
  input logic [N-1:0]     coef_i,
  input logic [W+N+1:0]   prod_o
);

  localparam int PW = W + N + 2;

  logic signed [PW-1:0] ref_now;
  assign ref_now = PW'(signed'(x_i)) * PW'(signed'({1'b0, coef_i}));

  generate
    if (OUT_REG) begin : g_reg
      logic primed;
      always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
      end

      AST_EXACT_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        primed |-> (signed'(prod_o) == $past(ref_now))); // R1

      AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (prod_o == '0)); // R2

      AST_ZERO_COEF: assert property (@(posedge clk) disable iff (rst)
        (coef_i == '0) |=> (prod_o == '0)); // R3

      AST_ZERO_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (x_i == '0) |=> (prod_o == '0)); // R3

      AST_NEG_SIGN: assert property (@(posedge clk) disable iff (rst)
        (x_i[W-1] && coef_i != '0) |=> prod_o[PW-1]); // R8

      AST_POS_SIGN: assert property (@(posedge clk) disable iff (rst)
        (!x_i[W-1] && x_i != '0 && coef_i != '0) |=> (signed'(prod_o) > 0)); // R8
    end else begin : g_comb
      always @(negedge clk) begin
        if (!rst) begin
          AST_COMB_PRODUCT: assert (signed'(prod_o) == ref_now); // R1
        end
      end
    end
  endgenerate

endmodule

bind csm_coef_mult csm_coef_mult_chk #(.W(W), .N(N), .OUT_REG(OUT_REG)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .x_i    (x_i),
  .coef_i (coef_i),
  .prod_o (prod_o)
);

// File: tb/tb_csm_coef_mult.sv
module tb_csm_coef_mult;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int N  = 16;
  localparam int PW = W + N + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  x    = '0;
  logic [N-1:0]  coef = '0;
  logic [PW-1:0] prod;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csm_coef_mult #(.W(W), .N(N), .OUT_REG(1'b1)) dut (
    .clk    (clk),
    .rst    (rst),
    .x_i    (x),
    .coef_i (coef),
    .prod_o (prod)
  );

  function automatic longint model(input logic [W-1:0] xv, input logic [N-1:0] cv);
    longint xs;
    longint cs;
    xs = longint'($signed(xv));
    cs = longint'(cv);
    return xs * cs;
  endfunction

  task automatic expect_val(input string tag, input longint expv, input string what);
    longint got;
    got = longint'($signed(prod));
    checks++;
    if (got != expv) begin
      failures++;
      $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, expv);
    end
  endtask

  // Drive one pair at a falling edge, read the result one cycle later.
  task automatic run_vec(input string tag, input logic [W-1:0] xv, input logic [N-1:0] cv);
    @(negedge clk);
    x = xv;
    coef = cv;
    @(negedge clk);
    expect_val(tag, model(xv, cv), $sformatf("x=%0d coef=%h", $signed(xv), cv));
  endtask

  initial begin
    longint pend;
    bit     have;
    void'($urandom(32'd20240611));

    // R2: reset holds the output at zero, even with busy inputs.
    @(negedge clk);
    x = 16'h1234;
    coef = 16'hFFFF;
    @(negedge clk);
    @(negedge clk);
    expect_val("R2", 0, "during reset");
    rst = 1'b0;

    // R3: zero operands.
    run_vec("R3", 16'sd12345, 16'h0000);
    run_vec("R3", 16'h0000, 16'hABCD);
    run_vec("R3", 16'h8000, 16'h0000);

    // R5: each pattern in the top slice (bits 15:13), sample negative and positive.
    for (int p = 0; p < 8; p++) begin
      run_vec("R5", -16'sd1234, 16'(p << 13));
      run_vec("R5", 16'sd777, 16'(p << 13));
    end
    // R5: each pattern in a middle slice (bits 9:7).
    for (int p = 0; p < 8; p++) run_vec("R5", -16'sd32768, 16'(p << 7));

    // R4: one nonzero slice at each full position, slice k at bits 15-3k:13-3k.
    for (int k = 0; k < 5; k++) begin
      run_vec("R4", 16'sd3001, 16'(5 << (13 - 3*k)));
      run_vec("R4", -16'sd3, 16'(6 << (13 - 3*k)));
    end

    // R6: the single trailing bit has weight 1.
    run_vec("R6", 16'sd4321, 16'h0001);
    run_vec("R6", -16'sd32768, 16'h0001);
    run_vec("R6", -16'sd9, 16'h0000 | 16'h0001);

    // R7: all-ones coefficient at the sample extremes.
    run_vec("R7", 16'sd32767, 16'hFFFF);
    run_vec("R7", -16'sd32768, 16'hFFFF);
    run_vec("R7", -16'sd1, 16'hFFFF);
    run_vec("R7", 16'sd1, 16'hFFFF);

    // R8: sign follows the sample, no overflow at the most negative sample.
    run_vec("R8", -16'sd32768, 16'h8000);
    run_vec("R8", -16'sd1, 16'h0001);
    run_vec("R8", 16'sd32767, 16'h0002);

    // R1: random stream, a new pair every cycle.
    have = 1'b0;
    pend = 0;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      if (have) expect_val("R1", pend, "stream");
      x = W'($urandom);
      coef = (i % 16 == 0) ? '1 : N'($urandom);
      pend = model(x, coef);
      have = 1'b1;
    end
    @(negedge clk);
    expect_val("R1", pend, "stream tail");

    // R2: reset in the middle of operation.
    run_vec("R1", -16'sd20000, 16'hC3A5);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    expect_val("R2", 0, "mid-run reset");
    rst = 1'b0;
    @(negedge clk);
    expect_val("R1", model(x, coef), "after reset release");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog expired got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule